// File: doc/BRIEF.md
# Page Permission Transition Rule Matcher

This block decides whether a request to change the permission word of a physical page is legal. It holds a small table of rules, and every slot of the table is compared at the same time against a key. The key has three parts: who is asking (a requester code), the page's present 11-bit permission word, and the 11-bit word being asked for. Each rule stores a value and a care mask for each of the three parts. A care bit of 0 makes that bit a don't-care, so one rule can cover a whole family of transitions. When a rule matches, the block returns its slot index and its 8-bit action code. The action code tells the caller what must happen to the page before the change takes effect. When no rule matches, the transition is refused.

Rules are written through a load port during the boot phase only. A small two-state controller starts in `ST_BOOT` after reset. It takes the transition `BOOT_TO_LOCKED` on the first cycle in which the boot-phase input is low, and it then stays in `ST_LOCKED` until the next reset. In `ST_LOCKED` the table contents cannot change. Any write attempted there is dropped and raises a one-cycle error pulse.

Top module: `perm_rule_matcher`

## Requirements
- R1: A slot matches a lookup when, for each of the three fields, every bit whose care bit is 1 equals the corresponding bit of the lookup key. Bits whose care bit is 0 are ignored.
- R2: When more than one slot matches, the response reports the lowest-numbered matching slot and that slot's action code.
- R3: A slot that has not been written since reset never matches. This applies whatever the key is.
- R4: A lookup that no slot matches is refused: `rsp_hit` is 0, and both `rsp_idx` and `rsp_act` are 0.
- R5: A lookup strobed on `lk_valid` in one cycle produces its response in the next cycle, with `rsp_valid` high. In a cycle that follows no strobe, `rsp_valid` and `rsp_hit` are low.
- R6: A load write is stored only when `boot_en` is high and the controller has not yet left `ST_BOOT`.
- R7: The controller leaves `ST_BOOT` for `ST_LOCKED` on the first clock edge at which `boot_en` is low. It remains in `ST_LOCKED`, shown by `locked`, until reset, even if `boot_en` is raised again. Writes made in `ST_LOCKED` leave the table unchanged.
- R8: A load write that is not stored raises `ld_err` for exactly one cycle, in the cycle after the write.
- R9: The matched slot's 8-bit action code is returned unchanged. Code 0 means no action, code 1 means wipe the page, and any other code is passed through as it is.
- R10: The permission word is laid out with bit 10 = shared and bit 9 = page-table. Bits 8:6 are the hypervisor's read/write/execute bits, bits 5:3 are the OS's, and bits 2:0 are the user's, with read highest. The requester codes are 0 = hypervisor, 1 = OS, 2 = user. The default rule set built from this layout grants these transitions and refuses every transition it does not list:
  - from all-clear to any state;
  - from any state back to all-clear with a wipe;
  - from write-only to execute-only on a code page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boot_en | input | 1 | Boot phase active |
| ld_we | input | 1 | Load-port write strobe |
| ld_idx | input | IDX_W | Slot index to write |
| ld_req_val | input | 2 | Requester value |
| ld_req_care | input | 2 | Requester care mask |
| ld_cur_val | input | 11 | Current-permission value |
| ld_cur_care | input | 11 | Current-permission care mask |
| ld_new_val | input | 11 | New-permission value |
| ld_new_care | input | 11 | New-permission care mask |
| ld_act | input | 8 | Action code of the rule |
| lk_valid | input | 1 | Lookup strobe |
| lk_req | input | 2 | Lookup requester |
| lk_cur | input | 11 | Present permission word |
| lk_new | input | 11 | Requested permission word |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Transition allowed |
| rsp_idx | output | IDX_W | Matched slot |
| rsp_act | output | 8 | Matched action code |
| ld_err | output | 1 | Rejected-write pulse |
| locked | output | 1 | Table locked |

## Verification
The bench loads the default rule set. It then checks the overlap between the all-clear rules, which a design that does not prefer the lowest index would resolve to the wipe rule. It checks lookups made before any load, where a design that ignores the valid bit would match the reset contents. It tries to let the OS grant itself access to a user page, which a lax mask comparison would allow. It also writes after the lock, including writes made after `boot_en` is raised again. A design whose lock is not sticky would overwrite rules there, and a design that drops the error pulse would be silent. Random keys drawn from rule words and from noise are compared against a rule model kept in the bench.

// File: rtl/perm_rule_pkg.sv
package perm_rule_pkg;
    localparam int PERM_W = 11;
    localparam int REQ_W  = 2;
    localparam int ACT_W  = 8;

    typedef struct packed {
        logic [REQ_W-1:0]  req_val;
        logic [REQ_W-1:0]  req_care;
        logic [PERM_W-1:0] cur_val;
        logic [PERM_W-1:0] cur_care;
        logic [PERM_W-1:0] new_val;
        logic [PERM_W-1:0] new_care;
        logic [ACT_W-1:0]  act;
    } rule_t;

    typedef enum logic {
        ST_BOOT   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_t;
endpackage

// File: rtl/prm_load_ctrl.sv
module prm_load_ctrl
    import perm_rule_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic boot_en,
    input  logic wr_req,
    output logic wr_ok,
    output logic locked,
    output logic err_pulse
);
    lock_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        wr_ok   = 1'b0;
        locked  = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                wr_ok = boot_en;
                if (!boot_en) state_d = ST_LOCKED; // BOOT_TO_LOCKED
            end
            ST_LOCKED: begin
                locked = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_pulse <= 1'b0;
        else        err_pulse <= wr_req & ~wr_ok;
    end
endmodule

// File: rtl/prm_rule_slot.sv
module prm_rule_slot
    import perm_rule_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  rule_t             wr_rule,
    input  logic [REQ_W-1:0]  key_req,
    input  logic [PERM_W-1:0] key_cur,
    input  logic [PERM_W-1:0] key_new,
    output logic              match,
    output logic [ACT_W-1:0]  act
);
    rule_t rule_q;
    logic  valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            rule_q  <= '0;
        end else if (wr_en) begin
            valid_q <= 1'b1;
            rule_q  <= wr_rule;
        end
    end

    always_comb begin
        match = valid_q
              && (((key_req ^ rule_q.req_val) & rule_q.req_care) == '0)
              && (((key_cur ^ rule_q.cur_val) & rule_q.cur_care) == '0)
              && (((key_new ^ rule_q.new_val) & rule_q.new_care) == '0);
        act = rule_q.act;
    end
endmodule

// File: rtl/prm_first_hit.sv
module prm_first_hit #(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     hits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/perm_rule_matcher.sv
module perm_rule_matcher
    import perm_rule_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_en,
    input  logic              ld_we,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [REQ_W-1:0]  ld_req_val,
    input  logic [REQ_W-1:0]  ld_req_care,
    input  logic [PERM_W-1:0] ld_cur_val,
    input  logic [PERM_W-1:0] ld_cur_care,
    input  logic [PERM_W-1:0] ld_new_val,
    input  logic [PERM_W-1:0] ld_new_care,
    input  logic [ACT_W-1:0]  ld_act,
    input  logic              lk_valid,
    input  logic [REQ_W-1:0]  lk_req,
    input  logic [PERM_W-1:0] lk_cur,
    input  logic [PERM_W-1:0] lk_new,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [ACT_W-1:0]  rsp_act,
    output logic              ld_err,
    output logic              locked
);
    logic             wr_ok;
    rule_t            wr_rule;
    logic [ENTRIES-1:0] hits;
    logic [ACT_W-1:0] slot_act [ENTRIES];
    logic             any_hit;
    logic [IDX_W-1:0] win_idx;

    prm_load_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_en   (boot_en),
        .wr_req    (ld_we),
        .wr_ok     (wr_ok),
        .locked    (locked),
        .err_pulse (ld_err)
    );

    always_comb begin
        wr_rule.req_val  = ld_req_val;
        wr_rule.req_care = ld_req_care;
        wr_rule.cur_val  = ld_cur_val;
        wr_rule.cur_care = ld_cur_care;
        wr_rule.new_val  = ld_new_val;
        wr_rule.new_care = ld_new_care;
        wr_rule.act      = ld_act;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        prm_rule_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (ld_we && wr_ok && (ld_idx == IDX_W'(g))),
            .wr_rule (wr_rule),
            .key_req (lk_req),
            .key_cur (lk_cur),
            .key_new (lk_new),
            .match   (hits[g]),
            .act     (slot_act[g])
        );
    end

    prm_first_hit #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .hits (hits),
        .any  (any_hit),
        .idx  (win_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_idx   <= '0;
            rsp_act   <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && any_hit;
            rsp_idx   <= (lk_valid && any_hit) ? win_idx : '0;
            rsp_act   <= (lk_valid && any_hit) ? slot_act[win_idx] : '0;
        end
    end
endmodule

// File: rtl/perm_rule_matcher_chk.sv
module perm_rule_matcher_chk
    import perm_rule_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             boot_en,
    input logic             ld_we,
    input logic             lk_valid,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [IDX_W-1:0] rsp_idx,
    input logic [ACT_W-1:0] rsp_act,
    input logic             ld_err,
    input logic             locked
);
    a_r5_rsp_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    a_r5_no_rsp_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_hit));
    a_r4_miss_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_idx == '0 && rsp_act == '0));
    a_r7_lock_on_boot_low: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_en |=> locked);
    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);
    a_r8_err_on_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_we && locked) |=> ld_err);
    a_r8_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_err && !ld_we) |=> !ld_err);
endmodule

bind perm_rule_matcher perm_rule_matcher_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .boot_en   (boot_en),
    .ld_we     (ld_we),
    .lk_valid  (lk_valid),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_idx   (rsp_idx),
    .rsp_act   (rsp_act),
    .ld_err    (ld_err),
    .locked    (locked)
);

// File: tb/perm_rule_matcher_test.sv
`timescale 1ns/1ps
module perm_rule_matcher_test;
    localparam int N  = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boot_en = 1'b1;
    logic ld_we = 1'b0;
    logic [IW-1:0] ld_idx = '0;
    logic [1:0]  ld_req_val = '0, ld_req_care = '0;
    logic [10:0] ld_cur_val = '0, ld_cur_care = '0, ld_new_val = '0, ld_new_care = '0;
    logic [7:0]  ld_act = '0;
    logic lk_valid = 1'b0;
    logic [1:0]  lk_req = '0;
    logic [10:0] lk_cur = '0, lk_new = '0;
    logic rsp_valid, rsp_hit, ld_err, locked;
    logic [IW-1:0] rsp_idx;
    logic [7:0] rsp_act;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench rule model
    logic [1:0]  m_rv [N], m_rc [N];
    logic [10:0] m_cv [N], m_cc [N], m_nv [N], m_nc [N];
    logic [7:0]  m_act [N];
    bit          m_ok [N];

    always #2 clk = ~clk;

    perm_rule_matcher uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [1:0] r, input logic [10:0] c, input logic [10:0] n,
                                  output bit hit, output int idx, output logic [7:0] a);
        hit = 0; idx = 0; a = 0;
        for (int i = 0; i < N; i++) begin
            if (!hit && m_ok[i] && ((r ^ m_rv[i]) & m_rc[i]) == 0
                && ((c ^ m_cv[i]) & m_cc[i]) == 0 && ((n ^ m_nv[i]) & m_nc[i]) == 0) begin
                hit = 1; idx = i; a = m_act[i];
            end
        end
    endfunction

    task automatic load(input int i, input logic [1:0] rv, input logic [1:0] rc,
                        input logic [10:0] cv, input logic [10:0] cc,
                        input logic [10:0] nv, input logic [10:0] nc, input logic [7:0] a,
                        input bit expect_store);
        @(negedge clk);
        ld_we = 1; ld_idx = IW'(i); ld_req_val = rv; ld_req_care = rc;
        ld_cur_val = cv; ld_cur_care = cc; ld_new_val = nv; ld_new_care = nc; ld_act = a;
        @(negedge clk);
        ld_we = 0;
        chk(expect_store ? "R6 no err on boot write" : "R8 err on locked write",
            32'(ld_err), 32'(!expect_store));
        if (expect_store) begin
            m_rv[i] = rv; m_rc[i] = rc; m_cv[i] = cv; m_cc[i] = cc;
            m_nv[i] = nv; m_nc[i] = nc; m_act[i] = a; m_ok[i] = 1;
        end
        @(negedge clk);
        chk("R8 err lasts one cycle", 32'(ld_err), 0);
    endtask

    task automatic look(input string req, input logic [1:0] r, input logic [10:0] c, input logic [10:0] n);
        bit h; int ix; logic [7:0] a;
        model(r, c, n, h, ix, a);
        @(negedge clk);
        lk_valid = 1; lk_req = r; lk_cur = c; lk_new = n;
        @(negedge clk);
        lk_valid = 0;
        chk({req, " valid"}, 32'(rsp_valid), 1);
        chk({req, " hit"}, 32'(rsp_hit), 32'(h));
        chk({req, " idx"}, 32'(rsp_idx), h ? 32'(ix) : 0);
        chk({req, " act"}, 32'(rsp_act), 32'(a));
        @(negedge clk);
        chk("R5 idle no valid", 32'(rsp_valid), 0);
    endtask

    function automatic logic [10:0] pick_word(input int sel);
        logic [10:0] pool [8];
        pool = '{11'h000, 11'h080, 11'h040, 11'h010, 11'h008, 11'h002, 11'h001, 11'h006};
        return (sel < 8) ? pool[sel] : 11'($urandom);
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < N; i++) m_ok[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("reset rsp_valid", 32'(rsp_valid), 0);
        chk("reset locked", 32'(locked), 0);
        chk("reset ld_err", 32'(ld_err), 0);

        // R3: empty table never matches
        look("R3 empty table", 2'd0, 11'h000, 11'h000);
        look("R3 empty table any", 2'd3, 11'h7FF, 11'h123);

        // R10 default rule set (bits: 10 S, 9 PT, 8:6 hyp RWX, 5:3 OS, 2:0 user)
        load(0, 2'd0, 2'b11, 11'h000, 11'h7FF, 11'h000, 11'h000, 8'd0, 1);
        load(1, 2'd0, 2'b11, 11'h000, 11'h000, 11'h000, 11'h7FF, 8'd1, 1);
        load(2, 2'd1, 2'b11, 11'h000, 11'h7FF, 11'h000, 11'h1C0, 8'd0, 1);
        load(3, 2'd1, 2'b11, 11'h000, 11'h1C0, 11'h000, 11'h7FF, 8'd1, 1);
        load(4, 2'd0, 2'b11, 11'h080, 11'h7FF, 11'h040, 11'h7FF, 8'd0, 1);
        load(5, 2'd1, 2'b11, 11'h010, 11'h7FF, 11'h008, 11'h7FF, 8'd0, 1);
        load(6, 2'd1, 2'b11, 11'h002, 11'h7FF, 11'h001, 11'h7FF, 8'd0, 1);
        load(7, 2'd3, 2'b11, 11'h000, 11'h000, 11'h000, 11'h000, 8'hA5, 1);

        look("R2 overlap lowest index", 2'd0, 11'h000, 11'h000);
        look("R10 hyp clear to any", 2'd0, 11'h000, 11'h5A3);
        look("R9 wipe action", 2'd0, 11'h1FF, 11'h000);
        look("R10 hyp code page", 2'd0, 11'h080, 11'h040);
        look("R10 os user code page", 2'd1, 11'h002, 11'h001);
        look("R4 os grabs user page", 2'd1, 11'h006, 11'h026);
        look("R1 os cannot set hyp bits", 2'd1, 11'h000, 11'h100);
        look("R1 user requester denied", 2'd2, 11'h000, 11'h004);
        look("R9 passthrough code", 2'd3, 11'h3C3, 11'h00F);

        // R7: lock
        @(negedge clk);
        boot_en = 0;
        @(negedge clk);
        chk("R7 locked after boot low", 32'(locked), 1);
        load(0, 2'd2, 2'b11, 11'h000, 11'h000, 11'h000, 11'h000, 8'h77, 0);
        look("R7 table unchanged", 2'd2, 11'h000, 11'h004);
        look("R7 slot0 intact", 2'd0, 11'h000, 11'h000);
        @(negedge clk);
        boot_en = 1;
        @(negedge clk);
        chk("R7 lock sticky", 32'(locked), 1);
        load(1, 2'd2, 2'b11, 11'h000, 11'h000, 11'h000, 11'h000, 8'h66, 0);
        look("R6 reboot write ignored", 2'd2, 11'h001, 11'h000);

        // random lookups against the model
        for (int k = 0; k < 400; k++) begin
            look("R1 random", 2'($urandom_range(3, 0)),
                 pick_word(int'($urandom_range(11, 0))), pick_word(int'($urandom_range(11, 0))));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule